// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block turns the system clock into the timing strobes that a synchronous serial shift engine needs. Two programmable stages are cascaded. The first stage is a prescaler that only takes even divisors. The second stage divides by the serial rate value plus one. The total bit period is the product of the two. The block never gates or builds a clock. It only produces single-cycle clock-enable pulses.

Two strobes come out. The half strobe pulses at every half bit period, so a downstream serial clock that toggles on it keeps a 50% duty cycle. The bit strobe marks the end of each full bit period and always coincides with every second half strobe.

Both settings are written through simple write strobes. The stored prescale value can be read back exactly as a register would show it, with its least significant bit always cleared. Any write, and any time the block is disabled, restarts both stages from zero, so the first period after a change is never shortened.

Top module: `bitrate_gen`

## Requirements
- R1: With stored prescale value P (even, nonzero) and rate value R, let H = (P/2)*(R+1). Counting the first clock cycle with `run_en` high as cycle 0, the first `half_tick` occurs in cycle H-1.
- R2: `bit_tick` is high only together with `half_tick`, on every second one, so the first `bit_tick` occurs in cycle 2H-1 and the bit period is P*(R+1) cycles.
- R3: A write on `presc_wr` stores `presc_wdata` with bit 0 forced to 0. `presc_rdata` shows the stored value from the cycle after the write.
- R4: After reset both stored fields are 0, `presc_rdata` reads 0, and no strobe is produced even with `run_en` high.
- R5: While the stored prescale value is 0 (including after writing 1), neither strobe is produced.
- R6: A write to either field restarts both stages. No strobe occurs in the write cycle, and the cycle after the write counts as cycle 0 of R1.
- R7: While `run_en` is low, no strobe is produced. Raising it starts counting from cycle 0 of R1.
- R8: Every rate value from 0 to 255 is accepted. At rate 0 the second stage passes every prescaler pulse, and at 255 it divides by 256.
- R9: Consecutive half strobes are exactly H cycles apart, so the second and third occur in cycles 2H-1 and 3H-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables strobe generation; low holds both stages at zero |
| presc_wr | input | 1 | Write strobe for the prescale field |
| presc_wdata | input | 8 | Prescale value to store (bit 0 is discarded) |
| rate_wr | input | 1 | Write strobe for the rate field |
| rate_wdata | input | 8 | Rate value to store (0 to 255) |
| presc_rdata | output | 8 | Stored prescale value as read back |
| half_tick | output | 1 | One-cycle pulse every half bit period |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit period |

## Verification
The hardest case to reach is a write that lands in the middle of a running period. The restart only shows as a missing early strobe: without it, a tick would appear a cycle or two after the write. The stimulus runs a configuration for part of a period, rewrites one field with the same value, and then measures the first strobe position against the full period. The largest rate is reached with the smallest prescaler, which keeps the run short while still driving the second stage to its terminal count of 255.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;

    localparam int unsigned PRESC_W = 8;
    localparam int unsigned RATE_W  = 8;

    // which half of the bit period the next half strobe closes
    typedef enum logic {
        PH_LEAD  = 1'b0,
        PH_TRAIL = 1'b1
    } half_phase_e;

endpackage

// File: rtl/bitrate_cfg.sv
module bitrate_cfg #(
    parameter int unsigned PW = bitrate_pkg::PRESC_W,
    parameter int unsigned RW = bitrate_pkg::RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          presc_wr,
    input  logic [PW-1:0] presc_wdata,
    input  logic          rate_wr,
    input  logic [RW-1:0] rate_wdata,
    output logic [PW-1:0] presc_q,
    output logic [RW-1:0] rate_q,
    output logic          cfg_touch
);

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
            rate_q  <= '0;
        end else begin
            if (presc_wr) presc_q <= {presc_wdata[PW-1:1], 1'b0};
            if (rate_wr)  rate_q  <= rate_wdata;
        end
    end

    assign cfg_touch = presc_wr | rate_wr;

    assert_even_store_R3: assert property (@(posedge clk) disable iff (rst)
        presc_wr |=> (presc_q == {$past(presc_wdata[PW-1:1]), 1'b0}));

    assert_rate_store_R8: assert property (@(posedge clk) disable iff (rst)
        rate_wr |=> (rate_q == $past(rate_wdata)));

endmodule

// File: rtl/bitrate_prediv.sv
module bitrate_prediv #(
    parameter int unsigned PW = bitrate_pkg::PRESC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [PW-1:0] presc_q,
    output logic          pre_tick
);

    localparam int unsigned CW = PW - 1;

    logic [CW-1:0] half_div;
    logic [CW-1:0] cnt;

    // an even divisor P splits into two halves of P/2 clocks each
    assign half_div = presc_q[PW-1:1];
    assign pre_tick = !restart && (half_div != '0) && (cnt == half_div - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart || pre_tick) cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (cnt < half_div));

    assert_restart_clears_pre_R6: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

endmodule

// File: rtl/bitrate_ratediv.sv
module bitrate_ratediv
    import bitrate_pkg::*;
#(
    parameter int unsigned RW = bitrate_pkg::RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          pre_tick,
    input  logic [RW-1:0] rate_q,
    output logic          half_tick,
    output logic          bit_tick
);

    logic [RW-1:0] rcnt;
    half_phase_e   phase;

    assign half_tick = pre_tick && (rcnt == rate_q);
    assign bit_tick  = half_tick && (phase == PH_TRAIL);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            rcnt  <= '0;
            phase <= PH_LEAD;
        end else if (pre_tick) begin
            rcnt <= half_tick ? '0 : rcnt + 1'b1;
            if (half_tick) phase <= (phase == PH_LEAD) ? PH_TRAIL : PH_LEAD;
        end
    end

    assert_bit_with_half_R2: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> half_tick);

    assert_phase_flips_R2: assert property (@(posedge clk) disable iff (rst)
        (half_tick && !restart) |=> (phase != $past(phase)));

    assert_restart_clears_rate_R6: assert property (@(posedge clk) disable iff (rst)
        restart |=> (rcnt == '0 && phase == PH_LEAD));

    assert_rcnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (rcnt <= rate_q));

endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen #(
    parameter int unsigned PW = bitrate_pkg::PRESC_W,
    parameter int unsigned RW = bitrate_pkg::RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en,
    input  logic          presc_wr,
    input  logic [PW-1:0] presc_wdata,
    input  logic          rate_wr,
    input  logic [RW-1:0] rate_wdata,
    output logic [PW-1:0] presc_rdata,
    output logic          half_tick,
    output logic          bit_tick
);

    logic [PW-1:0] presc_q;
    logic [RW-1:0] rate_q;
    logic          cfg_touch;
    logic          presc_idle;
    logic          restart;
    logic          pre_tick;

    bitrate_cfg #(.PW(PW), .RW(RW)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .presc_wr   (presc_wr),
        .presc_wdata(presc_wdata),
        .rate_wr    (rate_wr),
        .rate_wdata (rate_wdata),
        .presc_q    (presc_q),
        .rate_q     (rate_q),
        .cfg_touch  (cfg_touch)
    );

    // a zero divisor is illegal: hold everything at rest
    assign presc_idle = (presc_q[PW-1:1] == '0);
    assign restart    = !run_en || cfg_touch || presc_idle;

    bitrate_prediv #(.PW(PW)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .presc_q (presc_q),
        .pre_tick(pre_tick)
    );

    bitrate_ratediv #(.RW(RW)) u_rate (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .pre_tick (pre_tick),
        .rate_q   (rate_q),
        .half_tick(half_tick),
        .bit_tick (bit_tick)
    );

    assign presc_rdata = presc_q;

    assert_zero_presc_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (presc_rdata == '0) |-> (!half_tick && !bit_tick));

    assert_disabled_silent_R7: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> (!half_tick && !bit_tick));

    assert_write_cycle_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (presc_wr || rate_wr) |-> !half_tick);

endmodule

// File: tb/sim_bitrate_gen.sv
module sim_bitrate_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic       presc_wr = 1'b0;
    logic [7:0] presc_wdata = '0;
    logic       rate_wr = 1'b0;
    logic [7:0] rate_wdata = '0;
    logic [7:0] presc_rdata;
    logic       half_tick;
    logic       bit_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bitrate_gen u0 (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .presc_wr   (presc_wr),
        .presc_wdata(presc_wdata),
        .rate_wr    (rate_wr),
        .rate_wdata (rate_wdata),
        .presc_rdata(presc_rdata),
        .half_tick  (half_tick),
        .bit_tick   (bit_tick)
    );

    // columns: prescale written, rate written, expected readback, expected H
    localparam int NVEC = 9;
    localparam int VEC [NVEC][4] = '{
        '{  3,   0,   2,   1},
        '{  2,   0,   2,   1},
        '{  4,   2,   4,   6},
        '{  7,   5,   6,  18},
        '{ 10,   1,  10,  10},
        '{254,   0, 254, 127},
        '{  2, 255,   2, 256},
        '{  0,   3,   0,   0},
        '{  1,   4,   0,   0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_both(input int p, input int r);
        @(negedge clk);
        presc_wr = 1'b1; presc_wdata = p[7:0];
        rate_wr  = 1'b1; rate_wdata  = r[7:0];
        @(negedge clk);
        presc_wr = 1'b0; rate_wr = 1'b0;
    endtask

    // called at a negedge where cycle 0 begins (run_en already high)
    task automatic measure(input int h, input string tag);
        int h0 = -1, h1 = -1, h2 = -1, b0 = -1, nh = 0;
        int lim = (h == 0) ? 300 : 3 * h + 2;
        for (int n = 0; n < lim; n++) begin
            #1;
            if (half_tick) begin
                if (nh == 0) h0 = n;
                else if (nh == 1) h1 = n;
                else if (nh == 2) h2 = n;
                nh++;
            end
            if (bit_tick && b0 < 0) b0 = n;
            if (bit_tick && !half_tick) check(1'b0, {tag, " R2 bit without half"}, n, -1);
            @(negedge clk);
        end
        if (h == 0) begin
            check(nh == 0, {tag, " R5 no strobe at zero prescale"}, nh, 0);
            check(b0 < 0, {tag, " R5 no bit strobe"}, b0, -1);
        end else begin
            check(h0 == h - 1,     {tag, " R1 first half"}, h0, h - 1);
            check(h1 == 2 * h - 1, {tag, " R9 second half"}, h1, 2 * h - 1);
            check(h2 == 3 * h - 1, {tag, " R9 third half"}, h2, 3 * h - 1);
            check(b0 == 2 * h - 1, {tag, " R2 first bit"}, b0, 2 * h - 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R4: reset state
        #1;
        check(presc_rdata == 8'd0, "R4 readback after reset", presc_rdata, 0);
        run_en = 1'b1;
        @(negedge clk);
        measure(0, "R4 reset enabled");
        run_en = 1'b0;

        // vector table: R1 R2 R3 R5 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            write_both(VEC[i][0], VEC[i][1]);
            #1;
            check(presc_rdata == VEC[i][2][7:0], "R3 even readback", presc_rdata, VEC[i][2]);
            @(negedge clk);
            run_en = 1'b1;
            measure(VEC[i][3], $sformatf("vec%0d", i));
            run_en = 1'b0;
        end

        // R8: large divide in both stages
        write_both(200, 100);
        @(negedge clk);
        run_en = 1'b1;
        measure(10100, "R8 large");
        run_en = 1'b0;

        // R6: rate write in mid period restarts (H = 6)
        write_both(4, 2);
        @(negedge clk);
        run_en = 1'b1;
        repeat (4) @(negedge clk);
        rate_wr = 1'b1; rate_wdata = 8'd2;
        #1;
        check(half_tick == 1'b0, "R6 silent in rate write cycle", half_tick, 0);
        @(negedge clk);
        rate_wr = 1'b0;
        measure(6, "R6 rate rewrite");

        // R6: prescale write in mid period restarts
        repeat (3) @(negedge clk);
        presc_wr = 1'b1; presc_wdata = 8'd4;
        #1;
        check(half_tick == 1'b0, "R6 silent in prescale write cycle", half_tick, 0);
        @(negedge clk);
        presc_wr = 1'b0;
        measure(6, "R6 prescale rewrite");

        // R7: disabled run holds silent, then restarts from zero
        repeat (2) @(negedge clk);
        run_en = 1'b0;
        begin
            int seen = 0;
            for (int n = 0; n < 50; n++) begin
                #1;
                if (half_tick || bit_tick) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R7 no strobe while disabled", seen, 0);
        end
        check(presc_rdata == 8'd4, "R7 readback kept while disabled", presc_rdata, 4);
        run_en = 1'b1;
        measure(6, "R7 re-enable");
        run_en = 1'b0;

        // R4: reset clears stored fields
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(presc_rdata == 8'd0, "R4 readback after second reset", presc_rdata, 0);
        @(negedge clk);
        run_en = 1'b1;
        measure(0, "R4 after second reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule